// File: doc/BRIEF.md
# Chunked Invertible Substitution Layer Sequencer

This block applies a 4-bit nonlinear substitution to all 32 columns of a 128-bit state held as two XOR shares. It can run the substitution forward or in reverse. The state arrives in row form, as four 32-bit rows. On entry it is rewired into column form, where column j is the nibble built from bit j of each row. A small set of P parallel masked units then processes it. The state is rotated through those units one chunk of P columns at a time. Processed chunks return at the tail of the shift register, so after a full pass the columns are back in their original order. The result is rewired into row form on the outputs.

Each unit has a three-stage pipeline that takes one fresh random bit per cycle. The reverse direction reuses the forward core. A linear pre-map is placed in front of the core and a linear post-map after it, and both are selected by the direction latched at start. A plain value is loaded by driving it on share 0 with share 1 at zero. A stall input freezes the whole pass without losing data.

Top module: `sbl_layer_seq`

## Requirements
- R1: After reset, `done` is 0 and both output shares are all-zero.
- R2: Forward mode (`inverse`=0 at start): each column nibble x = {row3[j],row2[j],row1[j],row0[j]}, where row i is bits [32i+31:32i] of the recombined input (`in_sh0` XOR `in_sh1`), becomes F(x). F first sets t = x with bit 3 XORed by (x[2] AND x[1]), then rotates t left by one within the nibble. The result is written to the same column of `out_sh0` XOR `out_sh1`.
- R3: Inverse mode (`inverse`=1 at start): each column nibble y first becomes t, which is y rotated right by one. Then bit 3 of t is XORed with (t[2] AND t[1]).
- R4: After a start is accepted, with no stall, `done` is high for exactly one cycle. That cycle follows the 32/P + 3 advancing clock edges after the start edge.
- R5: Each cycle with `stall` high during a pass delays `done` by one cycle and leaves the result unchanged.
- R6: A `start` pulse while a pass is running is ignored, whatever the inputs carry at that time. The output shares keep the last result until the next accepted start.
- R7: The recombined result does not depend on how the input is split into shares or on the values on `rnd`.
- R8: For every P in {1,2,4,8,16,32}, an inverse pass fed with the output shares of a forward pass returns the original value.
- R9: The direction is sampled only when a start is accepted. Changing `inverse` during a pass has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass; accepted only when idle |
| inverse | input | 1 | 1 selects the reverse substitution, sampled at start |
| stall | input | 1 | Freezes chunk rotation and all pipeline stages |
| rnd | input | P | One fresh random bit per unit per advancing cycle |
| in_sh0 | input | 128 | Input share 0, row form |
| in_sh1 | input | 128 | Input share 1, row form |
| out_sh0 | output | 128 | Result share 0, row form (registered) |
| out_sh1 | output | 128 | Result share 1, row form (registered) |
| done | output | 1 | One-cycle pulse when a pass completes |

## Verification
Six copies of the block, one for each value of P, receive the same stimulus. A reference model in the bench computes the result and the `done` timing for every copy. Random values with a zero second share exercise the plain forward map. All-zero and all-one states isolate the fixed points of the nibble map from its rotation. Random second shares together with random mask bits show that the masking cancels. Forward-then-reverse passes, with and without stalls, show that the chunk order and the pipeline latency line up at every value of P. Runs with a second start or a changed direction in mid-pass show whether the control samples its inputs only once.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  localparam int NCOL    = 32;
  localparam int NROW    = 4;
  localparam int STATE_W = NCOL * NROW;
  localparam int PIPE    = 3;

  // row form -> column form: column j = {row3[j],row2[j],row1[j],row0[j]}
  function automatic logic [STATE_W-1:0] rows_to_cols(input logic [STATE_W-1:0] b);
    logic [STATE_W-1:0] c;
    for (int j = 0; j < NCOL; j++)
      for (int i = 0; i < NROW; i++)
        c[NROW*j+i] = b[NCOL*i+j];
    return c;
  endfunction

  function automatic logic [STATE_W-1:0] cols_to_rows(input logic [STATE_W-1:0] c);
    logic [STATE_W-1:0] b;
    for (int j = 0; j < NCOL; j++)
      for (int i = 0; i < NROW; i++)
        b[NCOL*i+j] = c[NROW*j+i];
    return b;
  endfunction

  // linear nibble map used after the nonlinear step, and its inverse
  function automatic logic [3:0] lin_fwd(input logic [3:0] x);
    return {x[2:0], x[3]};
  endfunction

  function automatic logic [3:0] lin_bwd(input logic [3:0] x);
    return {x[0], x[3:1]};
  endfunction
endpackage

// File: rtl/sbl_unit.sv
module sbl_unit
  import sbl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       inv,
  input  logic [3:0] x0,
  input  logic [3:0] x1,
  input  logic       r,
  output logic [3:0] y0,
  output logic [3:0] y1
);
  logic [3:0] p0_q, p1_q, q0_q, q1_q, y0_q, y1_q;
  logic       r_q;
  logic [3:0] pre0, pre1, c0, c1;
  logic       z0, z1;

  // stage 1 input: pre-map selected in reverse mode
  assign pre0 = inv ? lin_bwd(x0) : x0;
  assign pre1 = inv ? lin_bwd(x1) : x1;

  // masked AND of bits 2 and 1, remasked with the fresh bit
  assign z0 = (p0_q[2] & p0_q[1]) ^ r_q;
  assign z1 = (p1_q[2] & p1_q[1]) ^ ((p0_q[2] & p1_q[1]) ^ r_q) ^ (p1_q[2] & p0_q[1]);

  // core linear output, then post-map selected in reverse mode
  assign c0 = lin_fwd(q0_q);
  assign c1 = lin_fwd(q1_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      p0_q <= '0; p1_q <= '0; r_q <= 1'b0;
      q0_q <= '0; q1_q <= '0;
      y0_q <= '0; y1_q <= '0;
    end else if (en) begin
      p0_q <= pre0;
      p1_q <= pre1;
      r_q  <= r;
      q0_q <= {p0_q[3] ^ z0, p0_q[2:0]};
      q1_q <= {p1_q[3] ^ z1, p1_q[2:0]};
      y0_q <= inv ? lin_bwd(c0) : c0;
      y1_q <= inv ? lin_bwd(c1) : c1;
    end
  end

  assign y0 = y0_q;
  assign y1 = y1_q;
endmodule

// File: rtl/sbl_unit_array.sv
module sbl_unit_array #(
  parameter int P = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           inv,
  input  logic [4*P-1:0] x0,
  input  logic [4*P-1:0] x1,
  input  logic [P-1:0]   r,
  output logic [4*P-1:0] y0,
  output logic [4*P-1:0] y1
);
  for (genvar u = 0; u < P; u++) begin : g_unit
    sbl_unit u_unit (
      .clk (clk),
      .rst (rst),
      .en  (en),
      .inv (inv),
      .x0  (x0[4*u +: 4]),
      .x1  (x1[4*u +: 4]),
      .r   (r[u]),
      .y0  (y0[4*u +: 4]),
      .y1  (y1[4*u +: 4])
    );
  end
endmodule

// File: rtl/sbl_layer_seq.sv
module sbl_layer_seq
  import sbl_pkg::*;
#(
  parameter int P = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               inverse,
  input  logic               stall,
  input  logic [P-1:0]       rnd,
  input  logic [STATE_W-1:0] in_sh0,
  input  logic [STATE_W-1:0] in_sh1,
  output logic [STATE_W-1:0] out_sh0,
  output logic [STATE_W-1:0] out_sh1,
  output logic               done
);
  localparam int NCHUNK = NCOL / P;
  localparam int CW     = 4 * P;
  localparam int STEPS  = NCHUNK + PIPE;
  localparam int CNT_W  = $clog2(STEPS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  logic [STATE_W-1:0] st0_q, st1_q, st0_nx, st1_nx;
  logic [CW-1:0]      y0, y1;
  logic [CNT_W-1:0]   cnt_q;
  logic               busy_q, done_q, mode_q;
  logic               adv;

  assign adv = busy_q & ~stall;

  sbl_unit_array #(.P(P)) u_arr (
    .clk (clk),
    .rst (rst),
    .en  (adv),
    .inv (mode_q),
    .x0  (st0_q[CW-1:0]),
    .x1  (st1_q[CW-1:0]),
    .r   (rnd),
    .y0  (y0),
    .y1  (y1)
  );

  // head chunk leaves, processed chunk re-enters at the tail
  if (CW == STATE_W) begin : g_whole
    assign st0_nx = y0;
    assign st1_nx = y1;
  end else begin : g_shift
    assign st0_nx = {y0, st0_q[STATE_W-1:CW]};
    assign st1_nx = {y1, st1_q[STATE_W-1:CW]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st0_q  <= '0;
      st1_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start) begin
        st0_q  <= rows_to_cols(in_sh0);
        st1_q  <= rows_to_cols(in_sh1);
        mode_q <= inverse;
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (adv) begin
        st0_q <= st0_nx;
        st1_q <= st1_nx;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign out_sh0 = cols_to_rows(st0_q);
  assign out_sh1 = cols_to_rows(st1_q);
  assign done    = done_q;
endmodule

// File: rtl/sbl_layer_chk.sv
module sbl_layer_chk #(
  parameter int P = 4
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              busy,
  input logic                              stall,
  input logic                              done,
  input logic                              mode,
  input logic [$clog2(32/P+3)-1:0]         cnt,
  input logic [127:0]                      st0,
  input logic [127:0]                      st1
);
  localparam int STEPS = 32 / P + 3;

  // R4: done lasts a single cycle
  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: the step counter never passes the last step of a pass
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (int'(cnt) < STEPS));

  // R4: the end of a pass coincides with done
  a_r4_done_at_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R5: a stalled cycle changes neither the state nor the step
  a_r5_stall_freeze: assert property (@(posedge clk) disable iff (rst)
    (busy && stall) |=> ($stable(st0) && $stable(st1) && $stable(cnt)));

  // R9: the direction stays fixed during a pass
  a_r9_mode_held: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(mode));
endmodule

bind sbl_layer_seq sbl_layer_chk #(.P(P)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .busy  (busy_q),
  .stall (stall),
  .done  (done_q),
  .mode  (mode_q),
  .cnt   (cnt_q),
  .st0   (st0_q),
  .st1   (st1_q)
);

// File: tb/sim_sbl_layer_seq.sv
`timescale 1ns/1ps
module sim_sbl_layer_seq;
  localparam int NI = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, inverse = 1'b0, stall = 1'b0;
  logic [31:0] rnd = '0;
  logic [NI-1:0][127:0] in0, in1, o0, o1, orig;
  logic [NI-1:0] done;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < NI; g++) begin : g_dut
    sbl_layer_seq #(.P(1 << g)) u0 (
      .clk(clk), .rst(rst), .start(start), .inverse(inverse), .stall(stall),
      .rnd(rnd[(1<<g)-1:0]), .in_sh0(in0[g]), .in_sh1(in1[g]),
      .out_sh0(o0[g]), .out_sh1(o1[g]), .done(done[g])
    );
  end

  function automatic logic [127:0] ref_layer(input logic [127:0] x, input logic inv);
    logic [127:0] r;
    for (int j = 0; j < 32; j++) begin
      int n = x[96+j]*8 + x[64+j]*4 + x[32+j]*2 + x[j];
      int t;
      if (!inv) begin
        t = n ^ ((((n >> 2) & (n >> 1)) & 1) << 3);
        t = ((t << 1) | (t >> 3)) & 15;
      end else begin
        t = ((n >> 1) | (n << 3)) & 15;
        t = t ^ ((((t >> 2) & (t >> 1)) & 1) << 3);
      end
      r[j] = t[0]; r[32+j] = t[1]; r[64+j] = t[2]; r[96+j] = t[3];
    end
    return r;
  endfunction

  // behavioural model of each copy
  logic [NI-1:0] mbusy, mdone, mstarted;
  int mrem [NI];
  logic [NI-1:0][127:0] mexp, mlast;

  always @(posedge clk) begin
    for (int k = 0; k < NI; k++) begin
      if (rst) begin
        mbusy[k] <= 1'b0; mdone[k] <= 1'b0; mrem[k] <= 0;
        mexp[k] <= '0; mlast[k] <= '0; mstarted[k] <= 1'b0;
      end else begin
        mdone[k] <= 1'b0;
        if (!mbusy[k] && start) begin
          mbusy[k] <= 1'b1;
          mstarted[k] <= 1'b1;
          mrem[k] <= 32 / (1 << k) + 3;
          mexp[k] <= ref_layer(in0[k] ^ in1[k], inverse);
        end else if (mbusy[k] && !stall) begin
          if (mrem[k] == 1) begin
            mbusy[k] <= 1'b0; mdone[k] <= 1'b1; mlast[k] <= mexp[k];
          end
          mrem[k] <= mrem[k] - 1;
        end
      end
    end
  end

  task automatic check(input string t, input int k, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s P=%0d act=%h exp=%h", t, 1 << k, act, exp);
    end
  endtask

  // compare every copy on every clock
  always @(negedge clk) begin
    if (!rst) begin
      for (int k = 0; k < NI; k++) begin
        check(tag, k, {127'd0, done[k]}, {127'd0, mdone[k]});
        if (mdone[k])
          check(tag, k, o0[k] ^ o1[k], mexp[k]);
        else if (!mbusy[k])
          check(mstarted[k] ? "R6" : "R1", k, o0[k] ^ o1[k], mlast[k]);
      end
    end
  end

  task automatic wait_idle();
    do begin
      @(posedge clk); #1;
      rnd = $urandom;
    end while (mbusy != '0);
    @(posedge clk); #1;
    @(posedge clk); #1;
  endtask

  task automatic run(input string t, input logic inv, input bit stalls,
                     input bit restart, input bit flip);
    tag = t;
    inverse = inv;
    start = 1'b1;
    rnd = $urandom;
    @(posedge clk); #1;
    start = 1'b0;
    for (int c = 0; c < 40; c++) begin
      if (mbusy == '0) break;
      stall = stalls ? ($urandom % 3 == 0) : 1'b0;
      if (flip && c == 0) inverse = ~inv;
      if (restart && c == 1) begin
        start = 1'b1;
        inverse = ~inv;
        for (int k = 0; k < NI; k++) in0[k] = {$urandom, $urandom, $urandom, $urandom};
      end else start = 1'b0;
      rnd = $urandom;
      @(posedge clk); #1;
    end
    start = 1'b0;
    stall = 1'b0;
    wait_idle();
  endtask

  task automatic set_plain(input bit rnd_share);
    for (int k = 0; k < NI; k++) begin
      in0[k] = {$urandom, $urandom, $urandom, $urandom};
      in1[k] = rnd_share ? {$urandom, $urandom, $urandom, $urandom} : '0;
      orig[k] = in0[k] ^ in1[k];
    end
  endtask

  task automatic feed_back();
    for (int k = 0; k < NI; k++) begin
      in0[k] = o0[k];
      in1[k] = o1[k];
    end
  endtask

  task automatic check_round(input string t);
    for (int k = 0; k < NI; k++) check(t, k, o0[k] ^ o1[k], orig[k]);
  endtask

  initial begin
    in0 = '0; in1 = '0; orig = '0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    // R1: reset state
    for (int k = 0; k < NI; k++) begin
      check("R1", k, {127'd0, done[k]}, 128'd0);
      check("R1", k, o0[k] | o1[k], 128'd0);
    end

    // R2 then R3 and R8: plain forward, reverse back
    set_plain(1'b0);
    run("R2", 1'b0, 1'b0, 1'b0, 1'b0);
    feed_back();
    run("R3", 1'b1, 1'b0, 1'b0, 1'b0);
    check_round("R8");

    // R2: all-zero and all-one states
    for (int k = 0; k < NI; k++) begin in0[k] = '0; in1[k] = '0; end
    run("R2", 1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < NI; k++) begin in0[k] = '1; in1[k] = '0; end
    run("R2", 1'b0, 1'b0, 1'b0, 1'b0);

    // R7: random share split and random mask bits, then R8 round trip
    set_plain(1'b1);
    run("R7", 1'b0, 1'b0, 1'b0, 1'b0);
    feed_back();
    run("R7", 1'b1, 1'b0, 1'b0, 1'b0);
    check_round("R8");

    // R5: stalls in both directions
    set_plain(1'b1);
    run("R5", 1'b0, 1'b1, 1'b0, 1'b0);
    feed_back();
    run("R5", 1'b1, 1'b1, 1'b0, 1'b0);
    check_round("R8");

    // R6: second start with new data mid-pass
    set_plain(1'b0);
    run("R6", 1'b0, 1'b0, 1'b1, 1'b0);

    // R9: direction flipped mid-pass
    set_plain(1'b1);
    run("R9", 1'b1, 1'b0, 1'b0, 1'b1);
    feed_back();
    run("R9", 1'b0, 1'b1, 1'b0, 1'b1);
    check_round("R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog act=%0d exp<%0d", cyc, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule